// File: doc/BRIEF.md
# Interrupt Line Redirection Dispatcher

This block turns an event on one of a fixed set of interrupt input lines into a single delivery message. An event arrives as a valid strobe together with a line index. The dispatcher reads that line's 64-bit redirection entry from the flat entry bus, which the neighbouring register block drives. From the entry it either builds a message or suppresses the event. A message carries the destination byte, the destination addressing mode, the delivery mode, the vector and an 8-bit target mask.

Each event is classified in a fixed order. An out-of-range line index raises a line error. Otherwise a set mask bit drops the event silently. Otherwise a reserved delivery-mode code raises a mode error. Otherwise one message is loaded into a one-deep output slot. The slot hands the message off through a valid/ready handshake. While the slot is full and the consumer is stalling, the event input is held off through its own ready signal, so an accepted event is never lost.

Top module: `irq_redir_dispatch`

## Requirements
- R1: After synchronous reset, `msg_valid`, `err_mode` and `err_line` are 0 and `evt_ready` is 1.
- R2: An accepted event on a legal line whose entry is unmasked and uses a non-reserved mode makes `msg_valid` 1 on the next clock. The message carries the entry's vector (bits 7:0), delivery mode (bits 10:8), destination mode (bit 11) and destination (bits 63:56), all unchanged.
- R3: When the entry's mask bit (bit 16) is 1, the event produces no message and no error.
- R4: When an unmasked entry uses delivery mode 3 or 6, `err_mode` pulses high for exactly one cycle after acceptance and no message is produced.
- R5: A line index of 24 or more pulses `err_line` high for one cycle after acceptance and produces no message, whatever the other inputs are.
- R6: With destination mode 0 (physical), `msg_targets` has only bit d set for a destination ID d below 8. For an ID of 8 or more it is all zeros.
- R7: With destination mode 1 (logical), `msg_targets` equals the destination byte, so bit k selects target k.
- R8: While `msg_valid` is 1 and `msg_ready` is 0, every message output holds its value and `evt_ready` is 0.
- R9: Each accepted deliverable event yields exactly one message, and messages leave in acceptance order.
- R10: Entry bits 15:12 (trigger mode, remote-IRR, polarity, delivery status) and bits 55:17 have no effect on the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Interrupt event present |
| evt_line | input | 5 | Index of the line that fired |
| evt_ready | output | 1 | Dispatcher can take an event this cycle |
| entry_bus | input | 1536 | All 24 redirection entries, entry i in bits 64*i+63 : 64*i |
| msg_valid | output | 1 | Delivery message present |
| msg_ready | input | 1 | Consumer takes the message this cycle |
| msg_dest | output | 8 | Destination byte from the entry |
| msg_dest_logical | output | 1 | 1 = logical destination mode, 0 = physical |
| msg_mode | output | 3 | Delivery mode code |
| msg_vector | output | 8 | Interrupt vector |
| msg_targets | output | 8 | Decoded target mask |
| err_mode | output | 1 | One-cycle pulse: reserved delivery mode seen |
| err_line | output | 1 | One-cycle pulse: illegal line index seen |

## Verification
The hardest situation to reach from the ports is an event arriving while a message is stalled in the output slot. It has to stay pending without being taken, and then both messages must come out intact and in order. The stimulus forces `msg_ready` low and fires a deliverable event to fill the slot. It then presents a second event and holds it for several cycles before releasing the stall. After that phase, random stretches toggle `msg_ready` at random, so events repeatedly collide with a full slot. Random entries also mix masked, reserved-mode and illegal-line cases into that traffic.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    localparam int ENTRY_W = 64;
    localparam int DEST_W  = 8;
    localparam int VEC_W   = 8;
    localparam int TGT_W   = 8;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWPRI = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD_A = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_RSVD_B = 3'd6,
        DM_EXTINT = 3'd7
    } dlv_mode_e;

    // Field order follows the bit positions a neighbour decodes.
    typedef struct packed {
        logic [DEST_W-1:0] dest;         // 63:56
        logic [38:0]       spare;        // 55:17
        logic              mask;         // 16
        logic              trig_level;   // 15
        logic              remote_irr;   // 14
        logic              active_low;   // 13
        logic              busy;         // 12
        logic              dest_logical; // 11
        dlv_mode_e         mode;         // 10:8
        logic [VEC_W-1:0]  vector;       // 7:0
    } redir_entry_t;

    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              dest_logical;
        dlv_mode_e         mode;
        logic [VEC_W-1:0]  vector;
        logic [TGT_W-1:0]  targets;
    } dlv_msg_t;

    function automatic logic mode_is_reserved(dlv_mode_e m);
        return (m == DM_RSVD_A) || (m == DM_RSVD_B);
    endfunction

    function automatic logic [TGT_W-1:0] decode_targets(logic [DEST_W-1:0] dest,
                                                        logic logical);
        logic [TGT_W-1:0] t;
        t = '0;
        if (logical) begin
            t = dest;
        end else begin
            for (int i = 0; i < TGT_W; i++) begin
                if (dest == DEST_W'(i)) t[i] = 1'b1;
            end
        end
        return t;
    endfunction

endpackage

// File: rtl/redir_line_select.sv
module redir_line_select
    import irq_dispatch_pkg::*;
#(
    parameter int NUM_LINES = 24,
    parameter int LINE_W    = 5
) (
    input  logic [NUM_LINES*ENTRY_W-1:0] entry_bus,
    input  logic [LINE_W-1:0]            line,
    output redir_entry_t                 entry,
    output logic                         line_ok
);

    logic [ENTRY_W-1:0] slots [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_unpack
        assign slots[g] = entry_bus[g*ENTRY_W +: ENTRY_W];
    end

    always_comb begin
        line_ok = (32'(line) < NUM_LINES);
        entry   = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (32'(line) == i) entry = redir_entry_t'(slots[i]);
        end
    end

endmodule

// File: rtl/redir_entry_classify.sv
module redir_entry_classify
    import irq_dispatch_pkg::*;
(
    input  redir_entry_t entry,
    output logic         drop,
    output logic         rsvd,
    output logic         deliver,
    output dlv_msg_t     msg
);

    always_comb begin
        drop    = entry.mask;
        rsvd    = !entry.mask && mode_is_reserved(entry.mode);
        deliver = !entry.mask && !mode_is_reserved(entry.mode);

        msg.dest         = entry.dest;
        msg.dest_logical = entry.dest_logical;
        msg.mode         = entry.mode;
        msg.vector       = entry.vector;
        msg.targets      = decode_targets(entry.dest, entry.dest_logical);
    end

endmodule

// File: rtl/dlv_msg_slot.sv
module dlv_msg_slot
    import irq_dispatch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  dlv_msg_t load_msg,
    output logic     can_load,
    output logic     valid,
    input  logic     ready,
    output dlv_msg_t msg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
        end else if (load) begin
            valid <= 1'b1;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) msg <= load_msg;
    end

    assign can_load = !valid || ready;

    // R8: a stalled message keeps every field
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |=> valid && $stable(msg));

    // R8: nothing overwrites a stalled message
    a_r8_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        valid && !ready |-> !load);

endmodule

// File: rtl/irq_redir_dispatch.sv
module irq_redir_dispatch
    import irq_dispatch_pkg::*;
#(
    parameter int NUM_LINES = 24,
    localparam int LINE_W   = $clog2(NUM_LINES)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          evt_valid,
    input  logic [LINE_W-1:0]             evt_line,
    output logic                          evt_ready,
    input  logic [NUM_LINES*ENTRY_W-1:0]  entry_bus,
    output logic                          msg_valid,
    input  logic                          msg_ready,
    output logic [DEST_W-1:0]             msg_dest,
    output logic                          msg_dest_logical,
    output logic [2:0]                    msg_mode,
    output logic [VEC_W-1:0]              msg_vector,
    output logic [TGT_W-1:0]              msg_targets,
    output logic                          err_mode,
    output logic                          err_line
);

    redir_entry_t sel_entry;
    logic         line_ok;
    logic         drop, rsvd, deliver;
    dlv_msg_t     new_msg, out_msg;
    logic         can_load, accept, load;

    redir_line_select #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_select (
        .entry_bus (entry_bus),
        .line      (evt_line),
        .entry     (sel_entry),
        .line_ok   (line_ok)
    );

    redir_entry_classify u_classify (
        .entry   (sel_entry),
        .drop    (drop),
        .rsvd    (rsvd),
        .deliver (deliver),
        .msg     (new_msg)
    );

    assign evt_ready = can_load;
    assign accept    = evt_valid && evt_ready;
    assign load      = accept && line_ok && deliver;

    dlv_msg_slot u_slot (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_msg (new_msg),
        .can_load (can_load),
        .valid    (msg_valid),
        .ready    (msg_ready),
        .msg      (out_msg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_mode <= 1'b0;
            err_line <= 1'b0;
        end else begin
            err_mode <= accept && line_ok && rsvd;
            err_line <= accept && !line_ok;
        end
    end

    assign msg_dest         = out_msg.dest;
    assign msg_dest_logical = out_msg.dest_logical;
    assign msg_mode         = out_msg.mode;
    assign msg_vector       = out_msg.vector;
    assign msg_targets      = out_msg.targets;

    // R2 / R9: a deliverable accepted event shows up next cycle
    a_r2_msg_appears: assert property (@(posedge clk) disable iff (rst)
        accept && line_ok && deliver |=> msg_valid && !err_mode && !err_line);

    // R3: masked entries stay silent
    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        accept && line_ok && drop |=> !msg_valid && !err_mode && !err_line);

    // R4: reserved modes flag and emit nothing
    a_r4_reserved_flag: assert property (@(posedge clk) disable iff (rst)
        accept && line_ok && rsvd |=> err_mode && !msg_valid);

    // R5: illegal line flags and emits nothing
    a_r5_bad_line_flag: assert property (@(posedge clk) disable iff (rst)
        accept && !line_ok |=> err_line && !msg_valid && !err_mode);

    // R6: physical mode yields at most one target
    a_r6_phys_onehot: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_dest_logical |-> $onehot0(msg_targets));

    // R7: logical mode copies the destination byte
    a_r7_logical_copy: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_dest_logical |-> msg_targets == msg_dest);

    // R8: input is held off while the output stalls
    a_r8_input_held: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |-> !evt_ready);

endmodule

// File: tb/irq_redir_dispatch_tb_top.sv
module irq_redir_dispatch_tb_top;

    localparam int NL = 24;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            evt_valid = 1'b0;
    logic [4:0]      evt_line = '0;
    logic            evt_ready;
    logic [NL*64-1:0] entry_bus;
    logic            msg_valid;
    logic            msg_ready;
    logic [7:0]      msg_dest;
    logic            msg_dest_logical;
    logic [2:0]      msg_mode;
    logic [7:0]      msg_vector;
    logic [7:0]      msg_targets;
    logic            err_mode;
    logic            err_line;

    logic [63:0] tbl [NL];
    int checks = 0;
    int fails  = 0;
    bit ready_random = 1'b0;
    bit ready_force  = 1'b1;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NL; i++) entry_bus[i*64 +: 64] = tbl[i];
    end

    irq_redir_dispatch dut_i (
        .clk(clk), .rst(rst),
        .evt_valid(evt_valid), .evt_line(evt_line), .evt_ready(evt_ready),
        .entry_bus(entry_bus),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_dest(msg_dest), .msg_dest_logical(msg_dest_logical),
        .msg_mode(msg_mode), .msg_vector(msg_vector), .msg_targets(msg_targets),
        .err_mode(err_mode), .err_line(err_line)
    );

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(logic [7:0] dest, bit logical, logic [2:0] mode,
                                       logic [7:0] vec, bit masked);
        logic [63:0] e;
        e = '0;
        e[63:56] = dest;
        e[16]    = masked;
        e[11]    = logical;
        e[10:8]  = mode;
        e[7:0]   = vec;
        return e;
    endfunction

    function automatic logic [7:0] exp_targets(logic [7:0] dest, bit logical);
        if (logical) return dest;
        if (dest < 8) return 8'(1) << dest;
        return 8'h00;
    endfunction

    // expected payload {dest, logical, mode, vector, targets}
    function automatic logic [27:0] exp_payload(logic [63:0] e);
        return {e[63:56], e[11], e[10:8], e[7:0], exp_targets(e[63:56], e[11])};
    endfunction

    always @(posedge clk) begin
        #1 msg_ready = ready_random ? (($urandom % 4) != 0) : ready_force;
    end

    // scoreboard and monitor
    logic [27:0] exp_q[$];
    bit          pend_mode = 1'b0, pend_line = 1'b0;
    bit          prev_stall = 1'b0;
    logic [27:0] prev_pay = '0;

    always @(negedge clk) begin
        logic [27:0] pay;
        if (!rst) begin
            pay = {msg_dest, msg_dest_logical, msg_mode, msg_vector, msg_targets};
            check(err_mode == pend_mode, "R4 err_mode", 64'(err_mode), 64'(pend_mode));
            check(err_line == pend_line, "R5 err_line", 64'(err_line), 64'(pend_line));
            if (prev_stall) begin
                check(msg_valid && pay == prev_pay, "R8 stalled message held",
                      64'(pay), 64'(prev_pay));
            end
            if (msg_valid && !msg_ready) begin
                check(!evt_ready, "R8 evt_ready low while stalled", 64'(evt_ready), 64'd0);
            end
            if (msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R9 unexpected message", 64'(pay), 64'd0);
                end else begin
                    logic [27:0] e;
                    e = exp_q.pop_front();
                    check(pay == e, "R2/R6/R7/R9/R10 message payload", 64'(pay), 64'(e));
                end
            end
            prev_stall = msg_valid && !msg_ready;
            prev_pay   = pay;
            pend_mode  = 1'b0;
            pend_line  = 1'b0;
            if (evt_valid && evt_ready) begin
                if (evt_line >= NL) begin
                    pend_line = 1'b1;
                end else if (tbl[evt_line][16]) begin
                    // R3: masked, nothing expected
                end else if (tbl[evt_line][10:8] == 3'd3 || tbl[evt_line][10:8] == 3'd6) begin
                    pend_mode = 1'b1;
                end else begin
                    exp_q.push_back(exp_payload(tbl[evt_line]));
                end
            end
        end
    end

    task automatic send(logic [4:0] line);
        @(posedge clk); #1;
        evt_valid = 1'b1;
        evt_line  = line;
        @(negedge clk);
        while (!evt_ready) @(negedge clk);
        @(posedge clk); #1;
        evt_valid = 1'b0;
    endtask

    task automatic drain();
        ready_random = 1'b0;
        ready_force  = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NL; i++) tbl[i] = mk(8'(i), 1'b0, 3'd0, 8'h20 + 8'(i), 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!msg_valid && !err_mode && !err_line && evt_ready, "R1 reset state",
              {60'd0, msg_valid, err_mode, err_line, evt_ready}, 64'd1);
        @(posedge clk); #1 rst = 1'b0;

        // R2/R6 physical, several modes and IDs
        tbl[0] = mk(8'd3, 1'b0, 3'd0, 8'h41, 1'b0); send(5'd0);
        tbl[1] = mk(8'd7, 1'b0, 3'd7, 8'hFE, 1'b0); send(5'd1);
        tbl[2] = mk(8'd9, 1'b0, 3'd4, 8'h02, 1'b0); send(5'd2);   // R6 ID >= 8
        // R7 logical
        tbl[3] = mk(8'hA5, 1'b1, 3'd1, 8'h77, 1'b0); send(5'd3);
        tbl[23] = mk(8'h00, 1'b1, 3'd5, 8'h10, 1'b0); send(5'd23);
        // R10: ignored fields set
        tbl[4] = mk(8'd1, 1'b0, 3'd2, 8'h33, 1'b0) | 64'h00FF_FFFF_FFFE_F000; send(5'd4);
        // R3 masked
        tbl[5] = mk(8'd2, 1'b0, 3'd0, 8'h50, 1'b1); send(5'd5);
        // R4 reserved codes
        tbl[6] = mk(8'd2, 1'b0, 3'd3, 8'h51, 1'b0); send(5'd6);
        tbl[7] = mk(8'd2, 1'b1, 3'd6, 8'h52, 1'b0); send(5'd7);
        // R3: masked reserved stays silent
        tbl[8] = mk(8'd2, 1'b0, 3'd6, 8'h53, 1'b1); send(5'd8);
        // R5 illegal lines
        send(5'd24);
        send(5'd31);
        drain();

        // R8/R9 backpressure: fill slot, hold second event pending
        ready_force = 1'b0;
        tbl[9]  = mk(8'd4, 1'b0, 3'd0, 8'h90, 1'b0);
        tbl[10] = mk(8'h3C, 1'b1, 3'd1, 8'h91, 1'b0);
        send(5'd9);
        @(posedge clk); #1;
        evt_valid = 1'b1; evt_line = 5'd10;
        repeat (4) @(negedge clk);
        check(!evt_ready && msg_valid, "R8 input held while full",
              {62'd0, evt_ready, msg_valid}, 64'd1);
        @(posedge clk); #1 ready_force = 1'b1;
        @(negedge clk);
        while (!evt_ready) @(negedge clk);
        @(posedge clk); #1 evt_valid = 1'b0;
        drain();

        // constrained random
        ready_random = 1'b1;
        for (int n = 0; n < 400; n++) begin
            int ln;
            ln = ($urandom % 10 == 0) ? 24 + int'($urandom % 8) : int'($urandom % NL);
            if (ln < NL) begin
                tbl[ln] = {$urandom, $urandom};
                tbl[ln][16] = ($urandom % 4 == 0);
                if ($urandom % 2 == 0) tbl[ln][63:56] = 8'($urandom % 10);
            end
            send(5'(ln));
            if ($urandom % 3 == 0) repeat ($urandom % 3) @(posedge clk);
        end
        drain();
        check(exp_q.size() == 0, "R9 every accepted event delivered",
              64'(exp_q.size()), 64'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule